// File: doc/BRIEF.md
# Memory-to-Memory Vector Engine

This block runs one vector instruction at a time against a private word memory. The memory is split across four interleaved modules. An instruction names an operation, two source base addresses, a destination base address and an element count. The engine then walks the elements in ascending order. For each element it fetches both operands, applies the operation and stores the result at the destination. For the two reduction operations it folds the first source into a scalar and stores nothing.

A host presents the instruction word with a start strobe while the engine is idle. `busy_o` stays high for the whole run. `done_o` pulses once at the end. A scalar operand is captured at start for the vector-plus-scalar operation. The scalar result is presented on `result_o` at completion and held until the next instruction is accepted. At reset, every memory word is loaded with a value computed from its address, so that programs have known data to work on. Because the memory has no side port, the reduction operations are also the way to read its contents back.

Top module: `vec_engine`

## Requirements
- R1: The instruction word is packed with the opcode in bits [28:25], source-1 base in [24:19], source-2 base in [18:13], destination base in [12:7] and length in [6:0]. A start strobe while idle is accepted at that clock edge. From the next cycle, `busy_o` is high up to and including the `done_o` cycle. A start strobe while busy is ignored.
- R2: The memory holds 64 words of 16 bits in four modules, selected by address bits [1:0]. After reset, the word at address a holds (a*2357 + 17) mod 65536. After reset, `busy_o`, `done_o` and `result_o` are 0.
- R3: Opcode 1 stores A+B, opcode 2 stores A*B and opcode 3 stores A AND B, with the arithmetic results wrapped to 16 bits.
- R4: Opcode 4 stores the larger of A and B, compared as unsigned values.
- R5: Opcode 5 stores 1 when A > B (unsigned) and 0 otherwise, including when A equals B.
- R6: Opcode 8 stores S + A, wrapped to 16 bits, where S is the scalar captured at start.
- R7: Opcode 6 returns the wrapped sum of all A elements, and opcode 7 returns the unsigned maximum of all A elements, starting from 0. Neither writes memory. For every other accepted instruction, `result_o` is 0 at done.
- R8: With a non-zero length n and a known opcode, each element takes two cycles. `done_o` is high exactly in the cycle 2n+1 cycles after the accept edge and lasts one cycle. The elements are processed in order, so an element reads memory after every earlier element has been written.
- R9: A length of 0 completes with `done_o` in the cycle after acceptance and writes nothing.
- R10: Opcode 0 and opcodes 9 to 15 complete like a zero length: done in the cycle after acceptance, no writes, and a result of 0.
- R11: Element addresses are base plus index, modulo 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for the instruction word |
| instr_i | input | 29 | Instruction word (opcode, bases, length) |
| scalar_i | input | 16 | Scalar operand, captured at start |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Scalar result, valid at done and held after |

## Verification
On every cycle, the embedded properties check the following: the done pulse lasts one cycle, busy holds until done, a zero-length start is followed directly by done, at most one memory module is written per cycle, and nothing is written while idle. The bench's scenarios are needed for the rest. They show the arithmetic of each opcode, the order of element processing, address wrap, the scalar results, and that an ignored start or an unknown opcode leaves memory untouched. Memory contents are read back through full-memory sums and maxima.

// File: rtl/vec_pkg.sv
package vec_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd1,
        OP_MUL  = 4'd2,
        OP_AND  = 4'd3,
        OP_MAX2 = 4'd4,
        OP_GT   = 4'd5,
        OP_SUM  = 4'd6,
        OP_RMAX = 4'd7,
        OP_SADD = 4'd8
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_DONE
    } vst_e;

    function automatic logic op_known(input logic [3:0] op);
        return (op >= 4'd1) && (op <= 4'd8);
    endfunction

endpackage

// File: rtl/vec_bank.sv
module vec_bank #(
    parameter int DW      = 16,
    parameter int ADDR_W  = 6,
    parameter int IW      = 4,
    parameter int BANK_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] cell_q [DEPTH];

    function automatic logic [DW-1:0] seed_word(input logic [ADDR_W-1:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'd2357 + 32'd17;
        return DW'(t);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++)
                cell_q[j] <= seed_word(ADDR_W'(j * 4 + BANK_ID));
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata_a = cell_q[raddr_a];
    assign rdata_b = cell_q[raddr_b];

endmodule

// File: rtl/vec_alu.sv
module vec_alu
    import vec_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] s,
    input  logic [DW-1:0] acc,
    output logic [DW-1:0] elem,
    output logic          elem_wr,
    output logic          red,
    output logic [DW-1:0] acc_nxt
);
    always_comb begin
        elem    = '0;
        elem_wr = 1'b0;
        red     = 1'b0;
        acc_nxt = acc;
        case (op)
            OP_ADD:  begin elem = a + b; elem_wr = 1'b1; end
            OP_MUL:  begin elem = a * b; elem_wr = 1'b1; end
            OP_AND:  begin elem = a & b; elem_wr = 1'b1; end
            OP_MAX2: begin elem = (a > b) ? a : b; elem_wr = 1'b1; end
            OP_GT:   begin elem = {{(DW-1){1'b0}}, (a > b)}; elem_wr = 1'b1; end
            OP_SADD: begin elem = s + a; elem_wr = 1'b1; end
            OP_SUM:  begin red = 1'b1; acc_nxt = acc + a; end
            OP_RMAX: begin red = 1'b1; acc_nxt = (a > acc) ? a : acc; end
            default: ;
        endcase
    end

endmodule

// File: rtl/vec_engine.sv
module vec_engine
    import vec_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    localparam int LEN_W   = ADDR_W + 1,
    localparam int INSTR_W = 4 + 3 * ADDR_W + LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  scalar_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  result_o
);
    localparam int NBANK   = 4;
    localparam int IW      = ADDR_W - 2;
    localparam int LEN_LSB = 0;
    localparam int DST_LSB = LEN_W;
    localparam int S2_LSB  = DST_LSB + ADDR_W;
    localparam int S1_LSB  = S2_LSB + ADDR_W;
    localparam int OP_LSB  = S1_LSB + ADDR_W;

    typedef struct packed {
        vst_e              st;
        logic [3:0]        op;
        logic [ADDR_W-1:0] s1;
        logic [ADDR_W-1:0] s2;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic [DATA_W-1:0] sc;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] acc;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] ra, rb, wa;
    logic [DATA_W-1:0] rda [NBANK];
    logic [DATA_W-1:0] rdb [NBANK];
    logic [NBANK-1:0]  bank_we;
    logic [DATA_W-1:0] elem, acc_nxt;
    logic              elem_wr, red;
    logic [3:0]        in_op;
    logic [LEN_W-1:0]  in_len;

    assign ra     = q.s1  + q.idx[ADDR_W-1:0];
    assign rb     = q.s2  + q.idx[ADDR_W-1:0];
    assign wa     = q.dst + q.idx[ADDR_W-1:0];
    assign in_op  = instr_i[OP_LSB +: 4];
    assign in_len = instr_i[LEN_LSB +: LEN_W];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign bank_we[g] = (q.st == ST_WR) && elem_wr && (wa[1:0] == 2'(g));
        vec_bank #(.DW(DATA_W), .ADDR_W(ADDR_W), .IW(IW), .BANK_ID(g)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we[g]),
            .waddr   (wa[ADDR_W-1:2]),
            .wdata   (elem),
            .raddr_a (ra[ADDR_W-1:2]),
            .raddr_b (rb[ADDR_W-1:2]),
            .rdata_a (rda[g]),
            .rdata_b (rdb[g])
        );
    end

    vec_alu #(.DW(DATA_W)) u_alu (
        .op      (q.op),
        .a       (q.a),
        .b       (q.b),
        .s       (q.sc),
        .acc     (q.acc),
        .elem    (elem),
        .elem_wr (elem_wr),
        .red     (red),
        .acc_nxt (acc_nxt)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: if (start_i) begin
                d.op  = in_op;
                d.s1  = instr_i[S1_LSB +: ADDR_W];
                d.s2  = instr_i[S2_LSB +: ADDR_W];
                d.dst = instr_i[DST_LSB +: ADDR_W];
                d.len = in_len;
                d.idx = '0;
                d.acc = '0;
                d.sc  = scalar_i;
                d.st  = (in_len == '0 || !op_known(in_op)) ? ST_DONE : ST_RD;
            end
            ST_RD: begin
                d.a  = rda[ra[1:0]];
                d.b  = rdb[rb[1:0]];
                d.st = ST_WR;
            end
            ST_WR: begin
                if (red) d.acc = acc_nxt;
                d.idx = q.idx + 1'b1;
                d.st  = (d.idx == q.len) ? ST_DONE : ST_RD;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.st != ST_IDLE);
    assign done_o   = (q.st == ST_DONE);
    assign result_o = q.acc;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && in_len == '0) |=> done_o);

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R10
    idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || done_o) |-> (bank_we == '0));

endmodule

// File: tb/sim_vec_engine.sv
module sim_vec_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [28:0] instr_i = '0;
    logic [15:0] scalar_i = '0;
    logic        busy_o, done_o;
    logic [15:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [15:0] mm [64];

    always #2 clk = ~clk;

    vec_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .scalar_i(scalar_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [3:0] op, input int s1, input int s2,
                       input int dst, input int len, input logic [15:0] sc, input bit poke);
        bit known;
        int dlat;
        logic [15:0] acc, a, b, r;
        known = (op >= 1 && op <= 8);
        dlat  = (known && len > 0) ? 2 * len + 1 : 1;
        acc = 16'h0;
        if (known) begin
            for (int i = 0; i < len; i++) begin
                a = mm[(s1 + i) % 64];
                b = mm[(s2 + i) % 64];
                r = 16'h0;
                case (op)
                    4'd1: r = a + b;
                    4'd2: r = a * b;
                    4'd3: r = a & b;
                    4'd4: r = (a > b) ? a : b;
                    4'd5: r = (a > b) ? 16'd1 : 16'd0;
                    4'd8: r = sc + a;
                    4'd6: acc = acc + a;
                    4'd7: acc = (a > acc) ? a : acc;
                    default: ;
                endcase
                if (op != 4'd6 && op != 4'd7) mm[(dst + i) % 64] = r;
            end
        end
        @(negedge clk);
        start_i  = 1'b1;
        scalar_i = sc;
        instr_i  = {op, 6'(s1), 6'(s2), 6'(dst), 7'(len)};
        for (int k = 1; k <= dlat + 1; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (poke && k == 2) begin
                start_i = 1'b1;
                instr_i = {4'd1, 6'd0, 6'd1, 6'd0, 7'd40};
            end
            if (poke && k == 3) start_i = 1'b0;
            chk("R1", "busy", int'(busy_o), int'(k <= dlat));
            chk("R8", "done", int'(done_o), int'(k == dlat));
            if (k == dlat) chk(req, "result", int'(result_o), int'(acc));
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mm[i] = 16'((i * 2357 + 17) % 65536);
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2", "busy reset", int'(busy_o), 0);
        chk("R2", "done reset", int'(done_o), 0);
        chk("R2", "result reset", int'(result_o), 0);
        rst_n = 1'b1;
        // R2 / R7 initial contents via reductions
        run("R7", 4'd6, 0, 0, 0, 64, 16'h0, 1'b0);
        run("R7", 4'd7, 0, 0, 0, 64, 16'h0, 1'b0);
        run("R2", 4'd6, 5, 0, 0, 1, 16'h0, 1'b0);
        // R3
        run("R3", 4'd1, 0, 16, 32, 8, 16'h0, 1'b0);
        run("R3", 4'd2, 4, 5, 40, 6, 16'h0, 1'b1);   // R1 start while busy ignored
        run("R3", 4'd3, 1, 9, 48, 5, 16'h0, 1'b0);
        // R4
        run("R4", 4'd4, 2, 30, 20, 7, 16'h0, 1'b0);
        // R5 equal operands give 0, then mixed
        run("R5", 4'd5, 3, 3, 12, 3, 16'h0, 1'b0);
        run("R5", 4'd5, 10, 11, 50, 6, 16'h0, 1'b0);
        // R6
        run("R6", 4'd8, 7, 0, 56, 8, 16'hfff0, 1'b0);
        // R11 wrap of sources and destination
        run("R11", 4'd1, 60, 61, 62, 8, 16'h0, 1'b0);
        // R8 overlapping source and destination, element order
        run("R8", 4'd1, 20, 21, 21, 6, 16'h0, 1'b0);
        // R9 zero length
        run("R9", 4'd1, 0, 0, 0, 0, 16'h0, 1'b0);
        run("R9", 4'd6, 0, 0, 0, 0, 16'h0, 1'b0);
        // R10 unknown opcodes
        run("R10", 4'hc, 0, 1, 0, 5, 16'h0, 1'b0);
        run("R10", 4'h0, 3, 4, 8, 9, 16'h0, 1'b0);
        // R7 final memory readback
        run("R7", 4'd6, 0, 0, 0, 64, 16'h0, 1'b0);
        run("R7", 4'd7, 0, 0, 0, 64, 16'h0, 1'b0);
        run("R7", 4'd6, 32, 0, 0, 32, 16'h0, 1'b0);
        run("R7", 4'd7, 48, 0, 0, 16, 16'h0, 1'b0);
        summary();
    end

endmodule